// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the calendar date as seven byte-wide registers: seconds, minutes, hours, day of month, weekday, month and a two-digit year. Every field is packed BCD except the weekday, which is a plain binary count from 0 to 6. One pulse on the one-second tick input moves the time forward by a second. The carries ripple through minutes, hours, day, month and year, and the day limit follows the month length and the leap rule. The block always counts hours from 00 to 23.

Software loads the time through a byte-wide write port, normally as one burst that covers all seven time fields. A frame signal marks the whole burst. A tick that arrives while the frame is open is discarded, so a freshly loaded time cannot step forward partway through the load. A stop bit in a control register freezes the count. A sticky flag in the top bit of the seconds register marks the time as untrusted from reset until the seconds register is written. Any register can be read at any time through a combinational read port.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds register 0x80 (flag set, 00 seconds), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, control 0x00.
- R2: The time field addresses are 0x02 seconds, 0x03 minutes, 0x04 hours, 0x05 day, 0x06 weekday, 0x07 month and 0x08 year. A write stores only the field bits: 7 for seconds and minutes, 6 for hours and day, 3 for weekday, 5 for month and 8 for year. The unused upper bits read back as 0.
- R3: On an accepted tick the seconds count 00 to 59 in BCD. Each wrap of the seconds advances the minutes (00 to 59), and each wrap of the minutes advances the hours (00 to 23).
- R4: When the hours wrap, the day advances from 01 up to the month length and then returns to 01. The month length is 31, or 30 for months 04, 06, 09 and 11, or 28 or 29 for month 02.
- R5: February has 29 days when the year value is divisible by 4, including year 00, and 28 days otherwise.
- R6: When the day wraps, the month advances from 01 to 12 and then back to 01. Each month wrap advances the year from 00 to 99 and then back to 00.
- R7: The weekday, in binary in bits 2:0 of address 0x06, increases by one at each midnight and goes from 6 back to 0.
- R8: While bit 5 of the control register (address 0x00) is 1, ticks leave the time unchanged. The time registers can still be written.
- R9: Bit 7 of the seconds register is an integrity flag. It is 1 after reset and stays 1 until the seconds register is written, whatever value is written. After that write it reads 0.
- R10: A tick that arrives while the write frame is open, or while a write strobe is high, is discarded and is not applied later.
- R11: Addresses 0x01 and 0x09 to 0x0F read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| wr_frame | input | 1 | High for the whole of a register write burst |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Address of the byte being written |
| wr_data | input | 8 | Byte being written |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Contents of the addressed register, combinational |

## Verification
The hardest state to reach from the ports is a full carry chain that ends on a month boundary. Examples are the last second of 31 December 99, or the last second of 28 February in both leap and non-leap years. Ticking there from reset would take years of simulated seconds. The bench therefore loads each of these instants with a write burst and then applies only a few ticks. Random loads are biased towards the last seconds of the last day of a month, so the day and month carries fire often. The discarded-tick case is reached by raising the tick in the opening cycle of a write frame.

// File: rtl/cal_pkg.sv
// Package: shared widths and register addresses for the BCD calendar.
// Assumes a 4-bit register address space and byte-wide registers.
package cal_pkg;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int DAY_W  = 6;
    localparam int WDAY_W = 3;
    localparam int MON_W  = 5;
    localparam int YR_W   = 8;
    localparam int BYTE_W = 8;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_SEC  = 4'h2;
    localparam logic [3:0] A_MIN  = 4'h3;
    localparam logic [3:0] A_HR   = 4'h4;
    localparam logic [3:0] A_DAY  = 4'h5;
    localparam logic [3:0] A_WDAY = 4'h6;
    localparam logic [3:0] A_MON  = 4'h7;
    localparam logic [3:0] A_YR   = 4'h8;

    localparam int STOP_BIT = 5;
endpackage

// File: rtl/cal_bcd_step.sv
// Module: one packed-BCD field stepper (combinational).
// When inc is high it moves cur one step towards hi. At or above hi it
// returns to lo and raises wrap. Assumes W >= 5 and a low-nibble-first BCD layout.
module cal_bcd_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE   = 1;
    localparam logic [W-5:0] ONE_T = 1;

    // Next value of the field and its carry out.
    always_comb begin
        wrap = inc && (cur >= hi);
        if (!inc)
            nxt = cur;
        else if (cur >= hi)
            nxt = lo;
        else if (cur[3:0] >= 4'd9)
            nxt = {cur[W-1:4] + ONE_T, 4'h0};
        else
            nxt = cur + ONE;
    end
endmodule

// File: rtl/cal_month_len.sv
// Module: last valid day of a month, as BCD (combinational).
// Assumes BCD month 01..12 and BCD year 00..99. A year divisible by 4 is a leap year.
module cal_month_len (
    input  logic [cal_pkg::MON_W-1:0] mon,
    input  logic [cal_pkg::YR_W-1:0]  year,
    output logic [cal_pkg::DAY_W-1:0] last_day
);
    logic leap;

    // A BCD year is divisible by 4 when an even tens digit meets 0/4/8, or an odd one meets 2/6.
    always_comb begin
        if (!year[4])
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        else
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    end

    // Month length lookup.
    always_comb begin
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
// Module: BCD time-of-day and calendar counter with a byte write port,
// a combinational read port, a stop control and a sticky integrity flag.
// Assumes tick_1s is a single-cycle pulse and runs in 24-hour mode only.
module bcd_calendar #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              wr_frame,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import cal_pkg::*;

    logic [SEC_W-1:0]  sec_q,  sec_n;
    logic [MIN_W-1:0]  min_q,  min_n;
    logic [HR_W-1:0]   hr_q,   hr_n;
    logic [DAY_W-1:0]  day_q,  day_n, day_hi;
    logic [WDAY_W-1:0] wday_q, wday_n;
    logic [MON_W-1:0]  mon_q,  mon_n;
    logic [YR_W-1:0]   yr_q,   yr_n;
    logic              flag_q, stop_q;
    logic              sec_c, min_c, hr_c, day_c, mon_c, yr_c;
    logic              adv;
    logic [3:0]        wa, ra;

    assign wa = 4'(wr_addr);
    assign ra = 4'(rd_addr);

    // A tick counts only when the clock runs and no write is in progress.
    assign adv = tick_1s && !stop_q && !wr_frame && !wr_en;

    cal_bcd_step #(.W(SEC_W)) u_sec (.cur(sec_q), .lo(7'h00), .hi(7'h59), .inc(adv),
                                     .nxt(sec_n), .wrap(sec_c));
    cal_bcd_step #(.W(MIN_W)) u_min (.cur(min_q), .lo(7'h00), .hi(7'h59), .inc(sec_c),
                                     .nxt(min_n), .wrap(min_c));
    cal_bcd_step #(.W(HR_W))  u_hr  (.cur(hr_q),  .lo(6'h00), .hi(6'h23), .inc(min_c),
                                     .nxt(hr_n),  .wrap(hr_c));
    cal_month_len u_mlen (.mon(mon_q), .year(yr_q), .last_day(day_hi));
    cal_bcd_step #(.W(DAY_W)) u_day (.cur(day_q), .lo(6'h01), .hi(day_hi), .inc(hr_c),
                                     .nxt(day_n), .wrap(day_c));
    cal_bcd_step #(.W(MON_W)) u_mon (.cur(mon_q), .lo(5'h01), .hi(5'h12), .inc(day_c),
                                     .nxt(mon_n), .wrap(mon_c));
    cal_bcd_step #(.W(YR_W))  u_yr  (.cur(yr_q),  .lo(8'h00), .hi(8'h99), .inc(mon_c),
                                     .nxt(yr_n),  .wrap(yr_c));

    // Weekday: binary count modulo 7, stepped by the hour carry.
    always_comb begin
        if (!hr_c)
            wday_n = wday_q;
        else if (wday_q >= 3'd6)
            wday_n = 3'd0;
        else
            wday_n = wday_q + 3'd1;
    end

    // Register update: reset, then a byte write, then a time advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hr_q   <= '0;
            day_q  <= 6'h01;
            wday_q <= '0;
            mon_q  <= 5'h01;
            yr_q   <= '0;
            flag_q <= 1'b1;
            stop_q <= 1'b0;
        end else if (wr_en) begin
            case (wa)
                A_CTRL: stop_q <= wr_data[STOP_BIT];
                A_SEC: begin
                    sec_q  <= wr_data[SEC_W-1:0];
                    flag_q <= 1'b0;
                end
                A_MIN:  min_q  <= wr_data[MIN_W-1:0];
                A_HR:   hr_q   <= wr_data[HR_W-1:0];
                A_DAY:  day_q  <= wr_data[DAY_W-1:0];
                A_WDAY: wday_q <= wr_data[WDAY_W-1:0];
                A_MON:  mon_q  <= wr_data[MON_W-1:0];
                A_YR:   yr_q   <= wr_data[YR_W-1:0];
                default: ;
            endcase
        end else if (adv) begin
            sec_q  <= sec_n;
            min_q  <= min_n;
            hr_q   <= hr_n;
            day_q  <= day_n;
            wday_q <= wday_n;
            mon_q  <= mon_n;
            yr_q   <= yr_n;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (ra)
            A_CTRL:  rd_data = 8'(stop_q) << STOP_BIT;
            A_SEC:   rd_data = {flag_q, sec_q};
            A_MIN:   rd_data = {1'b0, min_q};
            A_HR:    rd_data = {2'b0, hr_q};
            A_DAY:   rd_data = {2'b0, day_q};
            A_WDAY:  rd_data = {5'b0, wday_q};
            A_MON:   rd_data = {3'b0, mon_q};
            A_YR:    rd_data = yr_q;
            default: rd_data = 8'h00;
        endcase
    end

    logic midnight;
    assign midnight = (sec_q == 7'h59) && (min_q == 7'h59) && (hr_q == 6'h23);

    // R8
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q) && $stable(day_q)));
    // R10
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(yr_q) && $stable(wday_q)));
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == A_SEC) |=> !flag_q);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && wa == A_SEC)) |=> flag_q);
    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sec_q == 7'h59) |=> (sec_q == 7'h00));
    // R7
    wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && midnight && wday_q == 3'd6) |=> (wday_q == 3'd0));
    // R6
    month_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && midnight && day_q == day_hi && mon_q == 5'h12) |=> (mon_q == 5'h01));
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       wr_frame = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Expected state, in binary.
    int e_s, e_m, e_h, e_d, e_w, e_mo, e_y;
    bit e_flag, e_stop;

    always #4 clk = ~clk;

    bcd_calendar #(.ADDR_W(4)) u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_frame(wr_frame),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_adv();
        if (e_stop) return;
        e_s++;
        if (e_s < 60) return;
        e_s = 0; e_m++;
        if (e_m < 60) return;
        e_m = 0; e_h++;
        if (e_h < 24) return;
        e_h = 0;
        e_w = (e_w + 1) % 7;
        e_d++;
        if (e_d <= mlen(e_mo, e_y)) return;
        e_d = 1; e_mo++;
        if (e_mo <= 12) return;
        e_mo = 1;
        e_y = (e_y + 1) % 100;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic check_time(string req);
        logic [7:0] v;
        rd(4'h2, v); chk(req, v, {e_flag, bcd(e_s)[6:0]});
        rd(4'h3, v); chk(req, v, bcd(e_m));
        rd(4'h4, v); chk(req, v, bcd(e_h));
        rd(4'h5, v); chk(req, v, bcd(e_d));
        rd(4'h6, v); chk(req, v, 8'(e_w));
        rd(4'h7, v); chk(req, v, bcd(e_mo));
        rd(4'h8, v); chk(req, v, bcd(e_y));
    endtask

    task automatic wr1(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_frame = 1; wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_frame = 0; wr_en = 0;
    endtask

    // Load all seven fields in one framed burst; tick_in_frame raises a tick in the opening cycle.
    task automatic load(int s, int m, int h, int d, int w, int mo, int y, bit tick_in_frame);
        logic [7:0] b [7];
        b[0] = bcd(s); b[1] = bcd(m); b[2] = bcd(h); b[3] = bcd(d);
        b[4] = 8'(w);  b[5] = bcd(mo); b[6] = bcd(y);
        @(negedge clk);
        wr_frame = 1; tick_1s = tick_in_frame;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            tick_1s = 0;
            wr_en = 1; wr_addr = 4'(i + 2); wr_data = b[i];
        end
        @(negedge clk);
        wr_en = 0; wr_frame = 0;
        e_s = s; e_m = m; e_h = h; e_d = d; e_w = w; e_mo = mo; e_y = y; e_flag = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_1s = 1;
            @(negedge clk);
            tick_1s = 0;
            model_adv();
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int r;
        r = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        e_s = 0; e_m = 0; e_h = 0; e_d = 1; e_w = 0; e_mo = 1; e_y = 0;
        e_flag = 1; e_stop = 0;

        // R1 reset contents
        check_time("R1");
        rd(4'h0, v); chk("R1", v, 8'h00);

        // R9 flag sticky across ticks, then cleared by a seconds write
        ticks(3);
        check_time("R9");
        wr1(4'h2, 8'hD9);
        e_s = 59; e_flag = 0;
        // R2 upper bits masked
        check_time("R2");
        wr1(4'h6, 8'hFE); e_w = 6;
        wr1(4'h4, 8'hE3); e_h = 23;
        check_time("R2");

        // R11 unused addresses read 0 and writes there change nothing
        wr1(4'h1, 8'hFF);
        wr1(4'hC, 8'hFF);
        rd(4'h1, v); chk("R11", v, 8'h00);
        rd(4'hC, v); chk("R11", v, 8'h00);
        check_time("R11");

        // R6 R7 end of century rollover
        load(59, 59, 23, 31, 6, 12, 99, 0);
        ticks(1);
        check_time("R6");
        chk("R7", 8'(e_w), 8'h00);

        // R5 leap years: 24 and 00 have 29 Feb, 23 does not
        load(59, 59, 23, 28, 2, 2, 24, 0); ticks(1); check_time("R5");
        chk("R5", bcd(e_d), 8'h29);
        ticks(86400 / 86400); check_time("R5");
        load(59, 59, 23, 29, 3, 2, 24, 0); ticks(1); check_time("R4");
        load(59, 59, 23, 28, 3, 2, 0, 0);  ticks(1); check_time("R5");
        load(59, 59, 23, 28, 4, 2, 23, 0); ticks(1); check_time("R5");
        chk("R5", bcd(e_mo), 8'h03);
        // R4 30-day month
        load(59, 59, 23, 30, 5, 4, 50, 0); ticks(1); check_time("R4");

        // R3 carries through minutes and hours
        load(55, 58, 9, 10, 1, 7, 33, 0); ticks(70); check_time("R3");

        // R8 stop freezes time; writes still work
        wr1(4'h0, 8'h20); e_stop = 1;
        rd(4'h0, v); chk("R8", v, 8'h20);
        ticks(5); check_time("R8");
        wr1(4'h3, 8'h42); e_m = 42;
        check_time("R8");
        wr1(4'h0, 8'h00); e_stop = 0;
        ticks(2); check_time("R8");

        // R10 tick in the opening cycle of a frame is dropped
        load(10, 20, 12, 15, 2, 6, 44, 1);
        check_time("R10");
        ticks(1); check_time("R10");

        // Random loads biased to month ends, then random tick runs
        for (int k = 0; k < 24; k++) begin
            int s, m, h, d, w, mo, y;
            mo = 1 + int'($urandom % 12); y = int'($urandom % 100);
            w = int'($urandom % 7);
            if ($urandom % 2 == 1) begin
                d = mlen(mo, y); h = 23; m = 59; s = 40 + int'($urandom % 20);
            end else begin
                d = 1 + int'($urandom % mlen(mo, y)); h = int'($urandom % 24);
                m = int'($urandom % 60); s = int'($urandom % 60);
            end
            load(s, m, h, d, w, mo, y, 0);
            ticks(int'($urandom % 90));
            check_time("R4");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule